// File: doc/BRIEF.md
# Predicted-Voltage Read-Retry Controller

This controller serves page reads from a host in a storage controller whose cells lose charge with age. For each request it looks up the predicted read reference voltage for the target block in a calibration table. It issues the first flash read at that voltage. It then collects the per-codeword decode results from the ECC engine. A page counts as read only when every codeword in it decodes.

If the page fails, the controller lowers the voltage code by one minimum step and reads again. It retries only downward, because retention loss only moves the best reference voltage lower. It stops at the first success, or when a configurable limit on attempts is reached. In either case it returns the attempt count, a failure flag and the last voltage code used. The response is held until the host acknowledges it.

When a retry succeeds below the predicted voltage and write-back is enabled, one strobe stores the working voltage into the block's table entry. The next read of that block then starts closer to the optimum.

Top module: `vpred_retry_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `fl_cmd_valid`, `tbl_rd_en` and `tbl_wr_en` are 0.
- R2: The cycle after a request is accepted, `tbl_rd_en` is 1 with the request's block on `tbl_rd_block`. Two cycles later the first flash command is issued for that block, with `fl_cmd_vcode` equal to the table value.
- R3: A codeword counts as correct only when its fail flag is 0 and its error count is at most 40. Up to 40 errors still passes; 41 or more fails. A page passes only when all 8 codewords of the attempt are correct.
- R4: Each retry uses a voltage code exactly one below the previous attempt's code. Once the code reaches 0, it stays at 0.
- R5: The controller stops at the first passing attempt. `rsp_attempts` equals the number of flash commands issued for the request.
- R6: If `max(retry_limit,1)` attempts all fail, the response has `rsp_fail`=1, `rsp_attempts` equal to that limit, and `rsp_vcode` equal to the last code tried. On success, `rsp_fail` is 0 and `rsp_vcode` is the passing code.
- R7: On success after more than one attempt with `wb_en`=1, `tbl_wr_en` pulses for exactly one cycle, with the block and the passing code, in the cycle before `rsp_valid` rises. There is no write on a first-attempt success, on a failure, or when `wb_en`=0.
- R8: While `rsp_valid` is 1 and `rsp_ack` is 0, the response fields stay unchanged and `req_ready` is 0. The cycle after the acknowledge, `rsp_valid` is 0 and `req_ready` is 1.
- R9: ECC beats that arrive while the controller is not waiting on a flash command have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_limit | input | CNT_W | Maximum number of attempts per request (0 acts as 1) |
| wb_en | input | 1 | Enable write-back of a lowered voltage after a successful retry |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_block | input | BLK_W | Block address of the request |
| req_page | input | PG_W | Page address within the block |
| rsp_valid | output | 1 | Response valid, held until acknowledged |
| rsp_ack | input | 1 | Host acknowledge of the response |
| rsp_fail | output | 1 | Page uncorrectable after all allowed attempts |
| rsp_attempts | output | CNT_W | Number of read attempts made |
| rsp_vcode | output | V_W | Last voltage code used |
| tbl_rd_en | output | 1 | Calibration table lookup strobe |
| tbl_rd_block | output | BLK_W | Block being looked up or written |
| tbl_rd_vcode | input | V_W | Table value, valid the cycle after the lookup strobe |
| tbl_wr_en | output | 1 | Table write-back strobe |
| tbl_wr_block | output | BLK_W | Block written back |
| tbl_wr_vcode | output | V_W | Voltage code written back |
| fl_cmd_valid | output | 1 | Flash page read command strobe |
| fl_cmd_block | output | BLK_W | Block of the flash read |
| fl_cmd_page | output | PG_W | Page of the flash read |
| fl_cmd_vcode | output | V_W | Reference voltage code for the flash read |
| ecc_valid | input | 1 | One codeword decode result |
| ecc_fail | input | 1 | Decoder flagged the codeword uncorrectable |
| ecc_errs | input | ERR_W | Raw bit errors found in the codeword |

## Verification
The bound checker watches several properties on every cycle. It confirms that each retry's code sits exactly one below the previous one with a floor at zero. It checks that the first command follows the lookup by two cycles at the table value, and that a response is frozen and blocks new requests until acknowledged. It also checks that a write-back strobe is always followed by a successful response, and that a failure is reported only at the attempt limit.

Other behaviours can only be shown by the bench's scenarios, which compare outcomes against an arithmetic model. These include the codeword pass boundary at 40 and 41 errors, and stopping at the first success with the correct attempt count. They also include the exact voltage written back and the absence of writes when write-back does not apply. Finally, they show that ECC beats arriving during the lookup leave the result unchanged. The sweep covers every start code, several distances to the optimum, and several retry limits.

// File: rtl/vpr_pkg.sv
`timescale 1ns/1ps
package vpr_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_LOOKUP = 3'd1,
    S_LOAD   = 3'd2,
    S_ISSUE  = 3'd3,
    S_WAIT   = 3'd4,
    S_WB     = 3'd5,
    S_RESP   = 3'd6
  } seq_state_t;

  // A codeword is bad when flagged or beyond the correction capability.
  function automatic logic cw_bad(input logic flag, input int unsigned errs,
                                  input int unsigned cap);
    return flag || (errs > cap);
  endfunction

  // Number of attempts actually allowed for a programmed limit.
  function automatic int unsigned eff_limit(input int unsigned lim);
    return (lim == 0) ? 1 : lim;
  endfunction

  // One downward step of the reference voltage, saturating at zero.
  function automatic int unsigned vstep(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/vpr_page_eval.sv
`timescale 1ns/1ps
module vpr_page_eval #(
  parameter int CW_PER_PAGE = 8,
  parameter int ERR_W       = 7,
  parameter int ECC_CAP     = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             beat_valid,
  input  logic             beat_fail,
  input  logic [ERR_W-1:0] beat_errs,
  output logic             beat_take,
  output logic             beat_bad,
  output logic             page_done,
  output logic             page_ok
);
  localparam int CW_W = $clog2(CW_PER_PAGE + 1);

  logic [CW_W-1:0] cnt_q;
  logic            any_bad_q;

  assign beat_take = active && beat_valid;
  assign beat_bad  = vpr_pkg::cw_bad(beat_fail, 32'(beat_errs), ECC_CAP);
  assign page_done = beat_take && (cnt_q == CW_W'(CW_PER_PAGE - 1));
  assign page_ok   = page_done && !any_bad_q && !beat_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      any_bad_q <= 1'b0;
    end else if (clear) begin
      cnt_q     <= '0;
      any_bad_q <= 1'b0;
    end else if (beat_take) begin
      cnt_q     <= cnt_q + 1'b1;
      any_bad_q <= any_bad_q | beat_bad;
    end
  end
endmodule

// File: rtl/vpr_volt_track.sv
`timescale 1ns/1ps
module vpr_volt_track #(
  parameter int V_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [V_W-1:0] load_val,
  input  logic           step,
  output logic [V_W-1:0] vcode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vcode <= '0;
    else if (load)  vcode <= load_val;
    else if (step)  vcode <= V_W'(vpr_pkg::vstep(32'(vcode)));
  end
endmodule

// File: rtl/vpr_seq.sv
`timescale 1ns/1ps
module vpr_seq #(
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                rsp_ack,
  input  logic                page_done,
  input  logic                page_ok,
  input  logic                wb_en,
  input  logic [CNT_W-1:0]    retry_limit,
  output vpr_pkg::seq_state_t state_q,
  output logic                accept,
  output logic                load_v,
  output logic                step_v,
  output logic                clear_eval,
  output logic [CNT_W-1:0]    attempts_q,
  output logic                fail_q
);
  import vpr_pkg::*;

  seq_state_t state_d;
  logic       at_limit;

  assign accept     = (state_q == S_IDLE) && req_valid;
  assign load_v     = (state_q == S_LOAD);
  assign clear_eval = (state_q == S_ISSUE);
  assign at_limit   = 32'(attempts_q) >= eff_limit(32'(retry_limit));
  assign step_v     = (state_q == S_WAIT) && page_done && !page_ok && !at_limit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (req_valid) state_d = S_LOOKUP;
      S_LOOKUP: state_d = S_LOAD;
      S_LOAD:   state_d = S_ISSUE;
      S_ISSUE:  state_d = S_WAIT;
      S_WAIT:
        if (page_done) begin
          if (page_ok)       state_d = (wb_en && attempts_q > 1) ? S_WB : S_RESP;
          else if (at_limit) state_d = S_RESP;
          else               state_d = S_ISSUE;
        end
      S_WB:     state_d = S_RESP;
      S_RESP:   if (rsp_ack) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      attempts_q <= '0;
      fail_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        attempts_q <= '0;
        fail_q     <= 1'b0;
      end else if (state_q == S_ISSUE) begin
        attempts_q <= attempts_q + 1'b1;
      end else if (state_q == S_WAIT && page_done && !page_ok && at_limit) begin
        fail_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpred_retry_ctrl.sv
`timescale 1ns/1ps
module vpred_retry_ctrl #(
  parameter int BLK_W       = 4,
  parameter int PG_W        = 3,
  parameter int V_W         = 4,
  parameter int CNT_W       = 4,
  parameter int ERR_W       = 7,
  parameter int CW_PER_PAGE = 8,
  parameter int ECC_CAP     = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] retry_limit,
  input  logic             wb_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BLK_W-1:0] req_block,
  input  logic [PG_W-1:0]  req_page,
  output logic             rsp_valid,
  input  logic             rsp_ack,
  output logic             rsp_fail,
  output logic [CNT_W-1:0] rsp_attempts,
  output logic [V_W-1:0]   rsp_vcode,
  output logic             tbl_rd_en,
  output logic [BLK_W-1:0] tbl_rd_block,
  input  logic [V_W-1:0]   tbl_rd_vcode,
  output logic             tbl_wr_en,
  output logic [BLK_W-1:0] tbl_wr_block,
  output logic [V_W-1:0]   tbl_wr_vcode,
  output logic             fl_cmd_valid,
  output logic [BLK_W-1:0] fl_cmd_block,
  output logic [PG_W-1:0]  fl_cmd_page,
  output logic [V_W-1:0]   fl_cmd_vcode,
  input  logic             ecc_valid,
  input  logic             ecc_fail,
  input  logic [ERR_W-1:0] ecc_errs
);
  import vpr_pkg::*;

  seq_state_t       state_q;
  logic             accept, load_v, step_v, clear_eval;
  logic [CNT_W-1:0] attempts_q;
  logic             fail_q;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  pg_q;
  logic [V_W-1:0]   vcode;

  // Named internal events, visible to the bound checker.
  logic ev_beat_take, ev_beat_bad, ev_page_done, ev_page_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      pg_q  <= '0;
    end else if (accept) begin
      blk_q <= req_block;
      pg_q  <= req_page;
    end
  end

  vpr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ack(rsp_ack),
    .page_done(ev_page_done), .page_ok(ev_page_ok), .wb_en(wb_en),
    .retry_limit(retry_limit), .state_q(state_q), .accept(accept),
    .load_v(load_v), .step_v(step_v), .clear_eval(clear_eval),
    .attempts_q(attempts_q), .fail_q(fail_q)
  );

  vpr_volt_track #(.V_W(V_W)) u_volt (
    .clk(clk), .rst_n(rst_n), .load(load_v), .load_val(tbl_rd_vcode),
    .step(step_v), .vcode(vcode)
  );

  vpr_page_eval #(.CW_PER_PAGE(CW_PER_PAGE), .ERR_W(ERR_W), .ECC_CAP(ECC_CAP)) u_eval (
    .clk(clk), .rst_n(rst_n), .clear(clear_eval), .active(state_q == S_WAIT),
    .beat_valid(ecc_valid), .beat_fail(ecc_fail), .beat_errs(ecc_errs),
    .beat_take(ev_beat_take), .beat_bad(ev_beat_bad),
    .page_done(ev_page_done), .page_ok(ev_page_ok)
  );

  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_RESP);
  assign rsp_fail     = fail_q;
  assign rsp_attempts = attempts_q;
  assign rsp_vcode    = vcode;
  assign tbl_rd_en    = (state_q == S_LOOKUP);
  assign tbl_rd_block = blk_q;
  assign tbl_wr_en    = (state_q == S_WB);
  assign tbl_wr_block = blk_q;
  assign tbl_wr_vcode = vcode;
  assign fl_cmd_valid = (state_q == S_ISSUE);
  assign fl_cmd_block = blk_q;
  assign fl_cmd_page  = pg_q;
  assign fl_cmd_vcode = vcode;
endmodule

// File: rtl/vpr_retry_checker.sv
`timescale 1ns/1ps
module vpr_retry_checker #(
  parameter int CNT_W = 4,
  parameter int V_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] retry_limit,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ack,
  input logic             rsp_fail,
  input logic [CNT_W-1:0] rsp_attempts,
  input logic [V_W-1:0]   rsp_vcode,
  input logic             tbl_rd_en,
  input logic [V_W-1:0]   tbl_rd_vcode,
  input logic             tbl_wr_en,
  input logic             fl_cmd_valid,
  input logic [V_W-1:0]   fl_cmd_vcode
);
  logic           have_prev;
  logic [V_W-1:0] prev_v;
  logic [V_W-1:0] exp_next;

  assign exp_next = (prev_v == '0) ? '0 : prev_v - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_v    <= '0;
    end else if (tbl_rd_en) begin
      have_prev <= 1'b0;
    end else if (fl_cmd_valid) begin
      have_prev <= 1'b1;
      prev_v    <= fl_cmd_vcode;
    end
  end

  p_first_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> ##2 (fl_cmd_valid && fl_cmd_vcode == $past(tbl_rd_vcode, 1)));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && have_prev) |-> (fl_cmd_vcode == exp_next));

  p_fail_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |->
      (32'(rsp_attempts) == vpr_pkg::eff_limit(32'(retry_limit))));

  p_attempt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_attempts != '0 &&
      32'(rsp_attempts) <= vpr_pkg::eff_limit(32'(retry_limit))));

  p_wr_then_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |=> (rsp_valid && !rsp_fail && !tbl_wr_en));

  p_hold_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_attempts) &&
      $stable(rsp_fail) && $stable(rsp_vcode)));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind vpred_retry_ctrl vpr_retry_checker #(.CNT_W(CNT_W), .V_W(V_W)) u_chk (.*);

// File: tb/sim_vpred_retry_ctrl.sv
`timescale 1ns/1ps
module sim_vpred_retry_ctrl;
  localparam int BLK_W = 4, PG_W = 3, V_W = 4, CNT_W = 4, ERR_W = 7, NCW = 8;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] retry_limit = '0;
  logic wb_en = 0, req_valid = 0, rsp_ack = 0;
  logic [BLK_W-1:0] req_block = '0;
  logic [PG_W-1:0]  req_page = '0;
  logic req_ready, rsp_valid, rsp_fail, tbl_rd_en, tbl_wr_en, fl_cmd_valid;
  logic [CNT_W-1:0] rsp_attempts;
  logic [V_W-1:0] rsp_vcode, tbl_rd_vcode, tbl_wr_vcode, fl_cmd_vcode;
  logic [BLK_W-1:0] tbl_rd_block, tbl_wr_block, fl_cmd_block;
  logic [PG_W-1:0] fl_cmd_page;
  logic ecc_valid = 0, ecc_fail = 0;
  logic [ERR_W-1:0] ecc_errs = '0;
  logic [V_W-1:0] tmem [16];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign tbl_rd_vcode = tmem[tbl_rd_block];

  vpred_retry_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One request; the page decodes when the voltage code is at most thr.
  task automatic run_req(input int b, input int thr, input int lim, input bit wb);
    int v0, leff, exp_att, last_v, ncmd, guard, wr_v, wr_b;
    bit exp_ok, wr_seen;
    v0 = int'(tmem[b]);
    leff = (lim == 0) ? 1 : lim;
    exp_ok = 0; exp_att = 0; last_v = v0;
    for (int k = 1; k <= leff; k++) begin
      last_v = (v0 - (k - 1) < 0) ? 0 : v0 - (k - 1);
      exp_att = k;
      if (last_v <= thr) begin exp_ok = 1; break; end
    end
    @(negedge clk);
    req_valid = 1; req_block = BLK_W'(b); req_page = PG_W'(b ^ 3);
    retry_limit = CNT_W'(lim); wb_en = wb;
    @(negedge clk);
    req_valid = 0;
    chk(tbl_rd_en == 1 && int'(tbl_rd_block) == b, "R2 lookup", int'(tbl_rd_block), b);
    ecc_valid = 1; ecc_fail = 1; ecc_errs = 7'd99;   // stray beats, R9
    ncmd = 0; guard = 0; wr_seen = 0; wr_v = -1; wr_b = -1;
    while (!rsp_valid && guard < 3000) begin
      guard++;
      if (fl_cmd_valid) begin
        int vk, exp_v;
        ecc_valid = 0; ecc_fail = 0;
        ncmd++;
        exp_v = (v0 - (ncmd - 1) < 0) ? 0 : v0 - (ncmd - 1);
        vk = int'(fl_cmd_vcode);
        chk(vk == exp_v, "R4 retry code", vk, exp_v);
        chk(int'(fl_cmd_block) == b && int'(fl_cmd_page) == (b ^ 3) % 8,
            "R2 cmd address", int'(fl_cmd_block), b);
        @(negedge clk);
        for (int i = 0; i < NCW; i++) begin
          bit bad;
          bad = (vk > thr) && (i == ncmd % NCW);
          ecc_valid = 1;
          ecc_fail  = bad && (ncmd % 2 == 0);
          ecc_errs  = (bad && ncmd % 2 == 1) ? 7'd41 : ((i % 2 == 1) ? 7'd40 : ERR_W'(i));
          @(negedge clk);
        end
        ecc_valid = 0; ecc_fail = 0;
      end else begin
        if (tbl_wr_en) begin
          wr_seen = 1; wr_v = int'(tbl_wr_vcode); wr_b = int'(tbl_wr_block);
        end
        @(negedge clk);
      end
    end
    ecc_valid = 0; ecc_fail = 0;
    chk(rsp_valid == 1, "R5 response arrives", int'(rsp_valid), 1);
    chk(int'(rsp_attempts) == exp_att, "R3/R5/R6 attempts", int'(rsp_attempts), exp_att);
    chk(ncmd == exp_att, "R5 commands issued", ncmd, exp_att);
    chk(rsp_fail == !exp_ok, "R3/R6 fail flag", int'(rsp_fail), int'(!exp_ok));
    chk(int'(rsp_vcode) == last_v, "R6 final code", int'(rsp_vcode), last_v);
    if (exp_ok && exp_att == 1)
      chk(int'(rsp_attempts) == 1, "R9 stray beats ignored", int'(rsp_attempts), 1);
    chk(wr_seen == (exp_ok && wb && exp_att > 1), "R7 write-back strobe",
        int'(wr_seen), int'(exp_ok && wb && exp_att > 1));
    if (wr_seen) begin
      chk(wr_v == last_v, "R7 write-back code", wr_v, last_v);
      chk(wr_b == b, "R7 write-back block", wr_b, b);
    end
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && int'(rsp_attempts) == exp_att &&
          int'(rsp_vcode) == last_v, "R8 hold", int'(rsp_valid), 1);
    end
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    chk(!rsp_valid && req_ready, "R8 release", int'(rsp_valid), 0);
  endtask

  initial begin
    int offs [6] = '{0, -1, -2, -4, 99, -99};
    int lims [4] = '{0, 1, 3, 5};
    for (int i = 0; i < 16; i++) tmem[i] = V_W'(i);
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !fl_cmd_valid && !tbl_rd_en && !tbl_wr_en,
        "R1 reset state", int'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fl_cmd_valid, "R1 after reset", int'(req_ready), 1);
    // stray beats while idle, R9
    ecc_valid = 1; ecc_fail = 1;
    repeat (2) @(negedge clk);
    ecc_valid = 0; ecc_fail = 0;
    for (int v = 0; v < 16; v++)
      foreach (offs[o])
        foreach (lims[l])
          run_req(v, v + offs[o], lims[l], ((v + o + l) % 2) == 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule